// File: doc/BRIEF.md
# Configurable 8-bit Galois Pseudo-Random Generator

This block produces an 8-bit pseudo-random state using parallel feedback. On every clock where stepping is enabled, the state moves one place toward the outgoing end. If the bit that leaves is 1, the whole shifted word is XORed with a tap word supplied at runtime. The shift direction can be left or right. The feedback can be a logical shift, where a zero enters, or a rotate, where the outgoing bit re-enters at the incoming end.

A seed is loaded with a one-cycle strobe. A loaded seed of zero, or a step result of zero, is replaced by 0x01, so the register never locks up in the all-zero state. A wrap flag pulses for one cycle each time a step brings the state back to the most recently loaded seed, so software can measure the cycle length directly.

With a maximal tap word the generator visits all 255 nonzero values before repeating. In shift mode the tap word must include the incoming-bit position: 0xB8 for a right shift and 0x1D for a left shift. In rotate mode the incoming bit is left out of the tap word: 0x38 for right and 0x1C for left.

Top module: `galois_lfsr8`

## Requirements
- R1: After reset, `state_out` is 0x01, `wrap_flag` is 0 and the stored seed is 0x01.
- R2: Right step. Bit 0 is the outgoing bit. The state shifts toward bit 0 and bit 7 receives 0 in shift mode. If the outgoing bit was 1, the result is XORed with `tap_word`.
- R3: Left step. Bit 7 is the outgoing bit. The state shifts toward bit 7 and bit 0 receives 0 in shift mode. If the outgoing bit was 1, the result is XORed with `tap_word`.
- R4: In rotate mode (`rotate_mode`=1), the incoming end receives the outgoing bit before the XOR. Rotate right with tap 0x38 gives the same sequence as shift right with tap 0xB8.
- R5: Shift left with tap 0x1D from seed 0x01 gives 0x02, 0x04, 0x08, 0x10, 0x20, 0x40, 0x80 and then 0x1D.
- R6: With a maximal tap word for the selected direction and mode, the state returns to a nonzero seed after exactly 255 steps.
- R7: `seed_load` takes priority over `step_en`. The next state is `seed_value`, or 0x01 when `seed_value` is 0x00, and this value becomes the stored seed.
- R8: With `seed_load`=0 and `step_en`=0, the state holds and `wrap_flag` is 0.
- R9: A step whose result would be 0x00 yields 0x01 instead. For example, shift left from 0x80 with tap 0x00 gives 0x01.
- R10: `wrap_flag` is 1 in exactly the cycles following a step, with no load, whose new state equals the stored seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_en | input | 1 | Advance one step this cycle |
| dir_left | input | 1 | 1 = shift left, 0 = shift right |
| rotate_mode | input | 1 | 1 = rotate feedback, 0 = logical shift |
| tap_word | input | 8 | Feedback XOR word |
| seed_value | input | 8 | Seed to load |
| seed_load | input | 1 | Load strobe; overrides step_en |
| state_out | output | 8 | Current state |
| wrap_flag | output | 1 | State has returned to the seed |

## Verification
The generator is run through full periods in all four direction and mode combinations with their maximal tap words. The period is measured with the wrap flag, which shows whether the incoming-bit handling is correct, since a wrong handling shortens the cycle. Rotate right with 0x38 is compared value by value against shift right with 0xB8. The power-of-two run from 0x01 pins down the left-shift edge and the first feedback. Loads of a zero seed, loads with the step enable held high, pauses with the enable low, and a zero tap word that drives the state to zero each exercise the lockup guard, the load priority and the hold.

// File: rtl/galois_lfsr8.sv
module galois_lfsr8 #(
  parameter int W = 8,
  parameter logic [W-1:0] RESET_SEED = 8'h01
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_en,
  input  logic         dir_left,
  input  logic         rotate_mode,
  input  logic [W-1:0] tap_word,
  input  logic [W-1:0] seed_value,
  input  logic         seed_load,
  output logic [W-1:0] state_out,
  output logic         wrap_flag
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] state_q, seed_q;
  logic         wrap_q;

  wire          out_bit  = dir_left ? state_q[W-1] : state_q[0];
  wire          in_bit   = rotate_mode & out_bit;
  wire [W-1:0]  shifted  = dir_left ? {state_q[W-2:0], in_bit} : {in_bit, state_q[W-1:1]};
  wire [W-1:0]  fed      = out_bit ? (shifted ^ tap_word) : shifted;
  wire [W-1:0]  step_val = (fed == '0) ? ONE : fed;
  wire [W-1:0]  load_val = (seed_value == '0) ? ONE : seed_value;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= RESET_SEED;
      seed_q  <= RESET_SEED;
      wrap_q  <= 1'b0;
    end else if (seed_load) begin
      state_q <= load_val;
      seed_q  <= load_val;
      wrap_q  <= 1'b0;
    end else if (step_en) begin
      state_q <= step_val;
      wrap_q  <= (step_val == seed_q);
    end else begin
      wrap_q  <= 1'b0;
    end
  end

  assign state_out = state_q;
  assign wrap_flag = wrap_q;

  assert_never_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    state_out != '0);

  assert_load_priority_R7: assert property (@(posedge clk) disable iff (!rst_n)
    seed_load |=> (state_out == (($past(seed_value) == '0) ? ONE : $past(seed_value))) && !wrap_flag);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!seed_load && !step_en) |=> $stable(state_out) && !wrap_flag);

  assert_wrap_after_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wrap_flag) |-> $past(step_en) && !$past(seed_load));

  assert_left_no_feedback_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !seed_load && dir_left && !state_out[W-1] && state_out[W-2:0] != '0)
      |=> state_out == {$past(state_out[W-2:0]), 1'b0});
endmodule

// File: tb/galois_lfsr8_tb.sv
module galois_lfsr8_tb;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       step_en = 0, dir_left = 0, rotate_mode = 0, seed_load = 0;
  logic [7:0] tap_word = 8'h00, seed_value = 8'h00;
  logic [7:0] state_out;
  logic       wrap_flag;

  int total = 0, bad = 0;
  int m_state = 1, m_seed = 1, m_wrap = 0;
  logic [7:0] rec [0:254];

  always #5 clk = ~clk;

  galois_lfsr8 u_dut (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .dir_left(dir_left),
    .rotate_mode(rotate_mode), .tap_word(tap_word), .seed_value(seed_value),
    .seed_load(seed_load), .state_out(state_out), .wrap_flag(wrap_flag));

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int model_step(int s);
    int o, n;
    if (dir_left) begin
      o = s / 128;
      n = (s * 2) % 256;
    end else begin
      o = s % 2;
      n = s / 2 + ((rotate_mode && o == 1) ? 128 : 0);
    end
    if (dir_left && rotate_mode && o == 1) n = n + 1;
    if (o == 1) n = n ^ int'(tap_word);
    if (n == 0) n = 1;
    return n;
  endfunction

  task automatic cyc(string req);
    if (seed_load) begin
      m_state = (seed_value == 0) ? 1 : int'(seed_value);
      m_seed = m_state;
      m_wrap = 0;
    end else if (step_en) begin
      m_state = model_step(m_state);
      m_wrap = (m_state == m_seed) ? 1 : 0;
    end else m_wrap = 0;
    @(posedge clk);
    @(negedge clk);
    chk(req, int'(state_out), m_state);
    chk({req, " wrap R10"}, int'(wrap_flag), m_wrap);
  endtask

  task automatic load(logic [7:0] s);
    seed_value = s; seed_load = 1;
    cyc("R7 load");
    seed_load = 0;
  endtask

  task automatic period(logic l, logic r, logic [7:0] t, logic [7:0] s, string req, bit store, bit cmp);
    int n;
    dir_left = l; rotate_mode = r; tap_word = t;
    load(s);
    step_en = 1;
    n = 0;
    for (int i = 0; i < 300; i++) begin
      cyc(req);
      if (n < 255) begin
        if (store) rec[n] = state_out;
        if (cmp) chk("R4 rotate equals shift", int'(state_out), int'(rec[n]));
      end
      n++;
      if (wrap_flag) break;
    end
    step_en = 0;
    chk({req, " period R6"}, n, 255);
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    join_none

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset state", int'(state_out), 1);
    chk("R1 reset wrap", int'(wrap_flag), 0);

    dir_left = 1; rotate_mode = 0; tap_word = 8'h1D;
    load(8'h01);
    step_en = 1;
    for (int i = 1; i <= 7; i++) begin
      cyc("R5 doubling");
      chk("R5 power of two", int'(state_out), 1 << i);
    end
    cyc("R5 first feedback");
    chk("R5 after 0x80", int'(state_out), 8'h1D);
    step_en = 0;

    period(1'b0, 1'b0, 8'hB8, 8'h01, "R2 right shift", 1'b1, 1'b0);
    period(1'b0, 1'b1, 8'h38, 8'h01, "R4 right rotate", 1'b0, 1'b1);
    period(1'b1, 1'b0, 8'h1D, 8'h5A, "R3 left shift", 1'b0, 1'b0);
    period(1'b1, 1'b1, 8'h1C, 8'hC3, "R4 left rotate", 1'b0, 1'b0);

    load(8'h00);
    chk("R7 zero seed", int'(state_out), 1);
    dir_left = 0; rotate_mode = 0; tap_word = 8'hB8; step_en = 1;
    repeat (5) cyc("R2 steps");
    seed_value = 8'h77; seed_load = 1;
    cyc("R7 priority");
    chk("R7 load over enable", int'(state_out), 8'h77);
    seed_load = 0;
    cyc("R2 step");
    step_en = 0;
    for (int i = 0; i < 4; i++) cyc("R8 hold");
    chk("R8 held value", int'(state_out), m_state);

    dir_left = 1; tap_word = 8'h00;
    load(8'h80);
    step_en = 1;
    cyc("R9 zero guard");
    chk("R9 zero replaced", int'(state_out), 1);
    step_en = 0;

    dir_left = 0; rotate_mode = 0; tap_word = 8'hB8;
    load(8'h04);
    step_en = 1;
    repeat (254) cyc("R6 run");
    step_en = 0;
    cyc("R8 pause");
    step_en = 1;
    cyc("R10 wrap after pause");
    chk("R10 wrap pulse", int'(wrap_flag), 1);
    cyc("R10 wrap drops");
    chk("R10 wrap one cycle", int'(wrap_flag), 0);
    step_en = 0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule